// File: doc/BRIEF.md
# Segmented Approximate Adder with Configurable Exact Upper Segment

This block is a combinational N-bit adder that never ripples a carry across the full operand width. The addition is split into short, overlapping sub-adders. Each sub-adder spans R+P bits. Its low P bits serve only to estimate the carry into its upper R bits, and it adds those P bits with a carry-in of zero. The lowest sub-adder keeps every bit it computes. The longest carry path is therefore one segment long, and it is independent of N.

The top EXACT_BITS of the result can instead come from one longer exact segment. That segment estimates its own carry-in from the P operand bits just below it, in the same way as any other sub-adder. Widening it trades delay for accuracy. Setting it to the full width turns the block into an ordinary adder.

A status output, `mispredict`, goes high whenever any segment's estimated carry differs from the true one. It is meant for collecting statistics in simulation. The parameters must satisfy WIDTH = RES_BITS·k + PRED_BITS for a whole number k. The exact segment must be a multiple of RES_BITS and must either leave at least one whole sub-adder below it or cover the whole width. Any other combination stops elaboration.

Top module: `seg_approx_adder`

## Requirements
- R1: The lowest RES_BITS+PRED_BITS result bits always equal the corresponding bits of the true sum.
- R2: Every sub-adder above the lowest produces its RES_BITS result bits by adding its RES_BITS+PRED_BITS operand window with carry-in zero and keeping the upper RES_BITS bits. With defaults (12, 2, 2, exact 6), 0x00F + 0x001 gives sum 0x000.
- R3: When no bit position has both operand bits set, the result and carry-out equal the true sum.
- R4: The exact upper segment adds the top EXACT_BITS operand bits together with a carry estimated from the PRED_BITS bits below them. With defaults, 0x03F + 0x001 gives sum 0x030 and carry-out 0.
- R5: With EXACT_BITS equal to WIDTH, {carry_out, sum} equals op_a + op_b for every input.
- R6: carry_out is the carry leaving the topmost segment. With defaults, 0xFFF + 0x001 gives carry-out 0 and sum 0xFF0, and 0x800 + 0x800 gives carry-out 1 and sum 0x000. With no exact segment (EXACT_BITS 0), 0xC00 + 0x400 gives carry-out 1 and sum 0x000.
- R7: mispredict is 1 exactly when {carry_out, sum} differs from the true (WIDTH+1)-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH | Approximate sum |
| carry_out | output | 1 | Carry from the topmost segment |
| mispredict | output | 1 | Some estimated carry was wrong (statistics only) |

## Verification
The adder is driven with several kinds of input. Hand-picked operands make a carry run through a whole prediction window, which separates an estimated carry from the true one. Operand pairs with no shared set bits can create no carry at all, so any deviation there points to a wiring fault rather than a prediction miss. Long pseudo-random streams show that the low segment and the full-width exact build always match a normal adder, and that the miss flag rises exactly when the result is wrong. Three builds run side by side (exact segment of 6, 12 and 0 bits), so the exact-segment, fully exact and fully segmented arrangements are each covered.

// File: rtl/seg_approx_adder.sv
module seg_approx_adder #(
  parameter int WIDTH      = 12,
  parameter int RES_BITS   = 2,
  parameter int PRED_BITS  = 2,
  parameter int EXACT_BITS = 6
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             mispredict
);
  localparam int SPAN        = RES_BITS + PRED_BITS;
  localparam int SEGS        = (WIDTH - PRED_BITS) / RES_BITS;
  localparam int APPROX_SEGS = (EXACT_BITS == WIDTH) ? 0 : SEGS - EXACT_BITS / RES_BITS;
  localparam int LOW_W       = (SPAN < WIDTH) ? SPAN : WIDTH;
  localparam bit LEGAL = (RES_BITS >= 1) && (PRED_BITS >= 1) && (SEGS >= 1) &&
                         ((WIDTH - PRED_BITS) % RES_BITS == 0) &&
                         (EXACT_BITS >= 0) && (EXACT_BITS % RES_BITS == 0) &&
                         ((EXACT_BITS == WIDTH) || (EXACT_BITS <= WIDTH - SPAN));

  logic [WIDTH:0] exact_full;
  assign exact_full = {1'b0, op_a} + {1'b0, op_b};

  generate
    if (!LEGAL) begin : g_bad
      $error("seg_approx_adder: illegal WIDTH/RES_BITS/PRED_BITS/EXACT_BITS combination");
    end

    if (EXACT_BITS == WIDTH) begin : g_full
      assign sum        = exact_full[WIDTH-1:0];
      assign carry_out  = exact_full[WIDTH];
      assign mispredict = 1'b0;
    end else begin : g_seg
      logic [APPROX_SEGS:0] miss;

      for (genvar i = 0; i < APPROX_SEGS; i++) begin : g_sub
        localparam int LO = i * RES_BITS;
        logic [SPAN:0] part;
        assign part = {1'b0, op_a[LO+:SPAN]} + {1'b0, op_b[LO+:SPAN]};
        if (i == 0) begin : g_first
          assign sum[SPAN-1:0] = part[SPAN-1:0];
          assign miss[i]       = 1'b0;
        end else begin : g_later
          logic [PRED_BITS:0] guess;
          assign guess = {1'b0, op_a[LO+:PRED_BITS]} + {1'b0, op_b[LO+:PRED_BITS]};
          assign sum[LO+PRED_BITS+:RES_BITS] = part[SPAN-1:PRED_BITS];
          assign miss[i] = guess[PRED_BITS] !=
                           (exact_full[LO+PRED_BITS] ^ op_a[LO+PRED_BITS] ^ op_b[LO+PRED_BITS]);
        end
        if (i == APPROX_SEGS - 1 && EXACT_BITS == 0) begin : g_top_cout
          assign carry_out = part[SPAN];
        end
      end

      if (EXACT_BITS > 0) begin : g_exact
        localparam int LO_E = WIDTH - EXACT_BITS - PRED_BITS;
        localparam int EW   = EXACT_BITS + PRED_BITS;
        logic [EW:0]        part;
        logic [PRED_BITS:0] guess;
        assign part  = {1'b0, op_a[LO_E+:EW]} + {1'b0, op_b[LO_E+:EW]};
        assign guess = {1'b0, op_a[LO_E+:PRED_BITS]} + {1'b0, op_b[LO_E+:PRED_BITS]};
        assign sum[WIDTH-1:WIDTH-EXACT_BITS] = part[EW-1:PRED_BITS];
        assign carry_out = part[EW];
        assign miss[APPROX_SEGS] = guess[PRED_BITS] !=
                                   (exact_full[WIDTH-EXACT_BITS] ^ op_a[WIDTH-EXACT_BITS] ^
                                    op_b[WIDTH-EXACT_BITS]);
      end else begin : g_no_exact
        assign miss[APPROX_SEGS] = 1'b0;
      end

      assign mispredict = |miss;
    end
  endgenerate

  always_comb begin
    assert_low_span_exact_R1: assert (sum[LOW_W-1:0] == exact_full[LOW_W-1:0])
      else $error("low segment differs from true sum");
    assert_no_generate_exact_R3: assert (((op_a & op_b) != '0) || ({carry_out, sum} == exact_full))
      else $error("carry-free operands gave an inexact result");
    if (EXACT_BITS == WIDTH) begin
      assert_full_width_exact_R5: assert ({carry_out, sum} == exact_full)
        else $error("full-width exact build is not a normal adder");
    end
    assert_clean_means_exact_R7: assert (mispredict || ({carry_out, sum} == exact_full))
      else $error("wrong result without mispredict");
    assert_miss_means_wrong_R7: assert (!mispredict || ({carry_out, sum} != exact_full))
      else $error("mispredict raised on a correct result");
  end
endmodule

// File: tb/test_seg_approx_adder.sv
module test_seg_approx_adder;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2ns clk = ~clk;

  logic [W-1:0] a, b;
  logic [W-1:0] s_mid, s_full, s_none;
  logic         c_mid, c_full, c_none;
  logic         m_mid, m_full, m_none;

  seg_approx_adder #(.WIDTH(W), .RES_BITS(2), .PRED_BITS(2), .EXACT_BITS(6)) i_seg_approx_adder (
    .op_a(a), .op_b(b), .sum(s_mid), .carry_out(c_mid), .mispredict(m_mid));
  seg_approx_adder #(.WIDTH(W), .RES_BITS(2), .PRED_BITS(2), .EXACT_BITS(W)) i_seg_approx_adder_full (
    .op_a(a), .op_b(b), .sum(s_full), .carry_out(c_full), .mispredict(m_full));
  seg_approx_adder #(.WIDTH(W), .RES_BITS(2), .PRED_BITS(2), .EXACT_BITS(0)) i_seg_approx_adder_none (
    .op_a(a), .op_b(b), .sum(s_none), .carry_out(c_none), .mispredict(m_none));

  int total = 0;
  int failed = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1ns;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1ns;
    chk("reset R1", {c_mid, s_mid}, '0);
    chk("reset R7", {12'd0, m_mid}, '0);
  endtask

  task automatic t_window_r2();
    apply(12'h00F, 12'h001);
    chk("R2 sum", {c_mid, s_mid}, 13'h0000);
    chk("R7 flag", {12'd0, m_mid}, 13'd1);
  endtask

  task automatic t_exact_seg_r4();
    apply(12'h03F, 12'h001);
    chk("R4 sum", {c_mid, s_mid}, 13'h0030);
    apply(12'h350, 12'h120);
    chk("R4 no-miss", {c_mid, s_mid}, 13'h0470);
  endtask

  task automatic t_carry_r6();
    apply(12'hFFF, 12'h001);
    chk("R6 ripple", {c_mid, s_mid}, 13'h0FF0);
    apply(12'h800, 12'h800);
    chk("R6 top carry", {c_mid, s_mid}, 13'h1000);
    apply(12'hC00, 12'h400);
    chk("R6 no exact seg", {c_none, s_none}, 13'h1000);
  endtask

  task automatic t_no_generate_r3();
    for (int n = 0; n < 800; n++) begin
      logic [W-1:0] x, y;
      step(); x = lfsr[W-1:0];
      step(); y = lfsr[W-1:0] & ~x;
      apply(x, y);
      chk("R3 exact seg6", {c_mid, s_mid}, {1'b0, x} + {1'b0, y});
      chk("R3 no exact seg", {c_none, s_none}, {1'b0, x} + {1'b0, y});
    end
  endtask

  task automatic t_sweep_r1_r5_r7();
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] x, y;
      logic [W:0]   t;
      step(); x = lfsr[W-1:0];
      step(); y = lfsr[W-1:0];
      apply(x, y);
      t = {1'b0, x} + {1'b0, y};
      chk("R5 full width", {c_full, s_full}, t);
      chk("R1 low bits", {9'd0, s_mid[3:0]}, {9'd0, t[3:0]});
      chk("R7 flag seg6", {12'd0, m_mid}, {12'd0, ({c_mid, s_mid} != t)});
      chk("R7 flag none", {12'd0, m_none}, {12'd0, ({c_none, s_none} != t)});
    end
    apply(12'hFFF, 12'hFFF);
    chk("R5 max", {c_full, s_full}, 13'h1FFE);
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_window_r2();
    t_exact_seg_r4();
    t_carry_r6();
    t_no_generate_r3();
    t_sweep_r1_r5_r7();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #800us;
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule